// File: doc/BRIEF.md
# LFSR Keystream Bit Cipher

This block is a bit-serial stream cipher. Its keystream comes from a 24-stage linear feedback shift register with the feedback polynomial x^24 + x^23 + x^22 + x^17 + 1. A host writes a 24-bit seed into a holding bank one byte at a time. It then pulses a load strobe, which copies the seed into the shift register. After that, each cycle with the input-valid flag high takes one data bit, XORs it with the current keystream bit and shifts the register one step. The result appears one cycle later on a registered output together with a valid flag.

Encryption and decryption are the same operation. A second instance loaded with the same seed and stepped the same number of times produces the same keystream, and XORing the ciphertext with it gives the plaintext back. A guard replaces an all-zero seed with a fixed nonzero value, so the register never enters the stuck all-zero state.

The register width, tap mask and default state are parameters. With the defaults the block is the 24-stage cipher described above.

Top module: `lfsr_cipher_top`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets the state to 24'h000001 and holds `out_valid` low. The seed bank resets to zero.
- R2: A cycle with `seed_we` high stores `seed_byte` in the seed bank at the position given by `seed_idx`: index 0 fills seed bits 7:0, index 1 fills bits 15:8 and index 2 fills bits 23:16.
- R3: A seed write with `seed_idx` = 3 leaves the seed bank unchanged.
- R4: A `seed_load` pulse copies the seed bank into the state at that edge. The load takes priority over stepping: when `in_valid` is also high, the data bit is dropped and `out_valid` is low on the next cycle.
- R5: Loading an all-zero seed puts 24'h000001 into the state.
- R6: The state advances only on cycles with `in_valid` high and `seed_load` low. On other cycles it holds, and `out_valid` is low on the next cycle.
- R7: Stage k is state bit k-1. One step shifts every bit up by one position and writes bit23^bit22^bit21^bit16 into bit 0. The keystream bit is state bit 23 before the step.
- R8: For an accepted input bit, `out_bit` equals that bit XOR the keystream bit, and it is presented with `out_valid` high one cycle after the input.
- R9: A second instance loaded with the same seed and fed the ciphertext in the same order returns the original bits.
- R10: From any nonzero seed, the state runs through all 2^W − 1 nonzero values before it repeats. With the default W = 24 this is 16,777,215 steps.
- R11: Seed writes without a load pulse do not change the running keystream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_we | input | 1 | Seed byte write strobe |
| seed_idx | input | 2 | Seed byte position |
| seed_byte | input | 8 | Seed byte value |
| seed_load | input | 1 | Copy seed bank into the state |
| in_valid | input | 1 | Input bit present; advances the register |
| in_bit | input | 1 | Plaintext or ciphertext bit |
| out_valid | output | 1 | Output bit present |
| out_bit | output | 1 | Input bit XOR keystream bit |

## Verification
The assertions check the following on every cycle:
- each seed byte lands in its own field, and a write to the unused index leaves the bank as it was;
- a load copies the bank into the state, or the default value when the bank is zero;
- idle cycles hold the state, and a step is a one-position shift;
- the state never becomes zero;
- the output-valid flag follows accepted inputs by exactly one cycle.

Other behaviour needs the bench's scenarios. The exact keystream values are compared against a reference register model. The round trip through a second instance shows that decryption recovers the data. The full-period property can only be shown by stepping through a whole cycle, so the bench does this on a narrow 8-stage build with a maximal tap mask: it checks that all 255 state windows are distinct and that the sequence then repeats.

// File: rtl/lfsr_cipher_pkg.sv
package lfsr_cipher_pkg;

    // Width of one seed write.
    localparam int unsigned SEED_LANE_W = 8;

    // What the shift register does on a given edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } lfsr_act_e;

endpackage

// File: rtl/lfsr_seed_bank.sv
module lfsr_seed_bank
    import lfsr_cipher_pkg::*;
#(
    parameter int unsigned W     = 24,
    parameter int unsigned IDX_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [SEED_LANE_W-1:0] wbyte,
    output logic [W-1:0]           seed
);

    localparam int unsigned NUM_LANES = (W + SEED_LANE_W - 1) / SEED_LANE_W;
    localparam int unsigned PAD_W     = NUM_LANES * SEED_LANE_W;

    typedef struct packed {
        logic [PAD_W-1:0] bank;
    } bank_st_t;

    bank_st_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            for (int k = 0; k < int'(NUM_LANES); k++) begin
                if (int'(idx) == k) begin
                    bank_d.bank[k*SEED_LANE_W +: SEED_LANE_W] = wbyte;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign seed = bank_q.bank[W-1:0];

    // R2: each lane receives the written byte
    for (genvar g = 0; g < int'(NUM_LANES); g++) begin : g_lane_chk
        a_r2_byte_lands: assert property (@(posedge clk) disable iff (rst)
            (we && int'(idx) == g) |=> bank_q.bank[g*SEED_LANE_W +: SEED_LANE_W] == $past(wbyte));
    end

    // R3: an index beyond the last lane changes nothing
    a_r3_bad_index_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && int'(idx) >= int'(NUM_LANES)) |=> $stable(bank_q));

endmodule

// File: rtl/lfsr_core.sv
module lfsr_core
    import lfsr_cipher_pkg::*;
#(
    parameter int unsigned    W            = 24,
    parameter logic [W-1:0]   TAPS         = 24'hE10000,
    parameter logic [W-1:0]   DEFAULT_SEED = 24'h000001
) (
    input  logic          clk,
    input  logic          rst,
    input  lfsr_act_e     act,
    input  logic [W-1:0]  load_val,
    output logic          key_bit
);

    typedef struct packed {
        logic [W-1:0] state;
    } core_st_t;

    core_st_t core_d, core_q;
    logic     fb;

    // Feedback: parity of the tapped stages.
    assign fb = ^(core_q.state & TAPS);

    always_comb begin
        core_d = core_q;
        unique case (act)
            ACT_LOAD: core_d.state = (load_val == '0) ? DEFAULT_SEED : load_val;
            ACT_STEP: core_d.state = {core_q.state[W-2:0], fb};
            default:  core_d.state = core_q.state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q.state <= DEFAULT_SEED;
        end else begin
            core_q <= core_d;
        end
    end

    assign key_bit = core_q.state[W-1];

    // R4: a nonzero seed lands unchanged
    a_r4_load_copies: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOAD && load_val != '0) |=> core_q.state == $past(load_val));

    // R5: zero seed is replaced by the default state
    a_r5_zero_seed_default: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOAD && load_val == '0) |=> core_q.state == DEFAULT_SEED);

    // R6: no step without an accepted input
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_HOLD) |=> $stable(core_q.state));

    // R7: a step moves every stage up by one
    a_r7_shift: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_STEP) |=> core_q.state[W-1:1] == $past(core_q.state[W-2:0]));

    // R10: the register never reaches the stuck zero state
    a_r10_never_zero: assert property (@(posedge clk) disable iff (rst)
        core_q.state != '0);

endmodule

// File: rtl/lfsr_cipher_top.sv
module lfsr_cipher_top
    import lfsr_cipher_pkg::*;
#(
    parameter int unsigned  W            = 24,
    parameter logic [W-1:0] TAPS         = 24'hE10000,
    parameter logic [W-1:0] DEFAULT_SEED = 24'h000001,
    parameter int unsigned  IDX_W        = (((W + 7) / 8) > 1) ? $clog2((W + 7) / 8) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_we,
    input  logic [IDX_W-1:0] seed_idx,
    input  logic [7:0]       seed_byte,
    input  logic             seed_load,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             out_valid,
    output logic             out_bit
);

    typedef struct packed {
        logic valid;
        logic data;
    } out_st_t;

    logic [W-1:0] seed_val;
    logic         key_bit;
    lfsr_act_e    act;
    out_st_t      out_d, out_q;

    lfsr_seed_bank #(
        .W     (W),
        .IDX_W (IDX_W)
    ) u_seed_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (seed_we),
        .idx   (seed_idx),
        .wbyte (seed_byte),
        .seed  (seed_val)
    );

    // Load wins over a step on the same edge.
    always_comb begin
        if (seed_load) begin
            act = ACT_LOAD;
        end else if (in_valid) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

    lfsr_core #(
        .W            (W),
        .TAPS         (TAPS),
        .DEFAULT_SEED (DEFAULT_SEED)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .load_val (seed_val),
        .key_bit  (key_bit)
    );

    always_comb begin
        out_d.valid = (act == ACT_STEP);
        out_d.data  = out_d.valid ? (in_bit ^ key_bit) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_bit   = out_q.data;

    // R8: every accepted input yields an output one cycle later
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !seed_load) |=> out_valid);

    // R6: idle cycles produce no output
    a_r6_idle_no_output: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !seed_load) |=> !out_valid);

    // R4: a load cycle drops any data bit
    a_r4_load_no_output: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> !out_valid);

endmodule

// File: tb/lfsr_cipher_top_bench.sv
module lfsr_cipher_top_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic seed_we;
    logic [1:0] seed_idx;
    logic [7:0] seed_byte;
    logic ld_t, ld_d, ld_n;
    logic iv_t, ib_t, iv_d, ib_d, iv_n, ib_n;
    logic ov_t, ob_t, ov_d, ob_d, ov_n, ob_n;

    int n_checks = 0;
    int n_fail   = 0;

    logic [23:0] m_top;
    logic [23:0] seed_mdl;
    logic        plain  [0:999];
    logic        cipher [0:999];
    logic        nbits  [0:262];
    bit          seen   [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    lfsr_cipher_top u_lfsr_cipher_top (
        .clk(clk), .rst(rst), .seed_we(seed_we), .seed_idx(seed_idx),
        .seed_byte(seed_byte), .seed_load(ld_t), .in_valid(iv_t), .in_bit(ib_t),
        .out_valid(ov_t), .out_bit(ob_t)
    );

    lfsr_cipher_top u_dec (
        .clk(clk), .rst(rst), .seed_we(seed_we), .seed_idx(seed_idx),
        .seed_byte(seed_byte), .seed_load(ld_d), .in_valid(iv_d), .in_bit(ib_d),
        .out_valid(ov_d), .out_bit(ob_d)
    );

    lfsr_cipher_top #(
        .W(8), .TAPS(8'hB8), .DEFAULT_SEED(8'h01), .IDX_W(1)
    ) u_narrow (
        .clk(clk), .rst(rst), .seed_we(seed_we), .seed_idx(seed_idx[0]),
        .seed_byte(seed_byte), .seed_load(ld_n), .in_valid(iv_n), .in_bit(ib_n),
        .out_valid(ov_n), .out_bit(ob_n)
    );

    // One step of the 24-stage register as stated in R7.
    function automatic logic [23:0] nxt(input logic [23:0] s);
        return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_seed(input logic [1:0] idx, input logic [7:0] b);
        seed_we = 1'b1; seed_idx = idx; seed_byte = b;
        tick();
        seed_we = 1'b0;
        case (idx)
            2'd0: seed_mdl[7:0]   = b;
            2'd1: seed_mdl[15:8]  = b;
            2'd2: seed_mdl[23:16] = b;
            default: ;
        endcase
    endtask

    // Load with a data bit offered at the same time (R4 priority).
    task automatic load_top();
        ld_t = 1'b1; iv_t = 1'b1; ib_t = 1'b1;
        tick();
        ld_t = 1'b0; iv_t = 1'b0;
        m_top = (seed_mdl == 24'h0) ? 24'h000001 : seed_mdl;
        chk(ov_t == 1'b0, "R4 load drops data", ov_t, 0);
    endtask

    task automatic send_top(input logic b, input string req);
        iv_t = 1'b1; ib_t = b;
        tick();
        iv_t = 1'b0;
        chk(ov_t == 1'b1, "R8 out_valid", ov_t, 1);
        chk(ob_t == (b ^ m_top[23]), req, ob_t, b ^ m_top[23]);
        m_top = nxt(m_top);
    endtask

    task automatic idle_top(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            chk(ov_t == 1'b0, "R6 idle no output", ov_t, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd24017);
        rst = 1'b1; seed_we = 1'b0; seed_idx = 2'd0; seed_byte = 8'h0;
        ld_t = 0; ld_d = 0; ld_n = 0; iv_t = 0; ib_t = 0;
        iv_d = 0; ib_d = 0; iv_n = 0; ib_n = 0;
        seed_mdl = 24'h0;
        tick(); tick();
        chk(ov_t == 1'b0, "R1 reset out_valid", ov_t, 0);
        rst = 1'b0;
        m_top = 24'h000001;

        // R1/R7: keystream from the reset state, zero data passes it through
        for (int i = 0; i < 40; i++) send_top(1'b0, "R1 R7 keystream from reset");

        // R2/R4: three-byte seed then load
        wr_seed(2'd0, 8'hA5); wr_seed(2'd1, 8'h3C); wr_seed(2'd2, 8'h96);
        load_top();
        for (int i = 0; i < 200; i++) send_top(1'($urandom), "R2 R8 seeded stream");

        // R3: unused index ignored
        wr_seed(2'd3, 8'hFF);
        load_top();
        for (int i = 0; i < 50; i++) send_top(1'($urandom), "R3 index 3 ignored");

        // R5: zero seed replaced by default
        wr_seed(2'd0, 8'h00); wr_seed(2'd1, 8'h00); wr_seed(2'd2, 8'h00);
        load_top();
        for (int i = 0; i < 50; i++) send_top(1'($urandom), "R5 zero seed guard");

        // R11: seed writes without load leave the keystream alone
        for (int i = 0; i < 20; i++) send_top(1'($urandom), "R11 before write");
        wr_seed(2'd1, 8'h77); wr_seed(2'd2, 8'h01);
        for (int i = 0; i < 30; i++) send_top(1'($urandom), "R11 after write");
        load_top();

        // R6: random mix of idle and active cycles
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 3) == 0) idle_top(1);
            else send_top(1'($urandom), "R6 R7 random gaps");
        end

        // R9: round trip through a second instance
        wr_seed(2'd0, 8'h5E); wr_seed(2'd1, 8'hC1); wr_seed(2'd2, 8'h2B);
        ld_d = 1'b1; load_top(); ld_d = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            plain[i] = 1'($urandom);
            send_top(plain[i], "R8 encrypt");
            cipher[i] = ob_t;
        end
        for (int i = 0; i < 1000; i++) begin
            iv_d = 1'b1; ib_d = cipher[i];
            tick();
            iv_d = 1'b0;
            chk(ov_d == 1'b1 && ob_d == plain[i], "R9 round trip", ob_d, plain[i]);
        end

        // R10: full period on the 8-stage build
        wr_seed(2'd0, 8'h5A);
        ld_n = 1'b1; tick(); ld_n = 1'b0;
        for (int i = 0; i < 263; i++) begin
            iv_n = 1'b1; ib_n = 1'b0;
            tick();
            nbits[i] = ob_n;
        end
        iv_n = 1'b0;
        for (int i = 0; i < 256; i++) seen[i] = 1'b0;
        begin
            int dup;
            dup = 0;
            for (int i = 0; i < 255; i++) begin
                int w;
                w = 0;
                for (int j = 0; j < 8; j++) w = (w << 1) | int'(nbits[i + j]);
                if (w == 0 || seen[w]) dup++;
                seen[w] = 1'b1;
            end
            chk(dup == 0, "R10 all 255 states distinct", dup, 0);
        end
        for (int i = 0; i < 8; i++)
            chk(nbits[i + 255] == nbits[i], "R10 repeat after 2^W-1", nbits[i + 255], nbits[i]);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule